// File: doc/BRIEF.md
# Prefetch-Aware RRIP Way Replacement

This block holds the replacement state of one set in a 16-way last-level cache. Each way has a 2-bit re-reference prediction value (RRPV) from 0 to 3. A higher value predicts that the line will be reused later, so it is closer to eviction. The surrounding cache controller reports hits and fills on a way, tagged as demand or prefetch. It also sets three mode pins: one picks static or bimodal insertion, one enables special handling of prefetch fills, and one enables special handling of prefetch hits. When a miss needs a victim, the controller pulses a search request. The block returns the way to evict.

The mode pins let the controller treat prefetched data differently from demand data:
- A prefetch fill can be inserted at the most distant prediction.
- A prefetch hit can leave the line's prediction as it was. Lines that prefetching brings in easily then age out sooner than lines only demand traffic can bring in.

The victim is offered on a valid/ready pair. `vic_valid` rises once the search has found a way. `vic_valid` and `vic_way` then hold still until the cycle in which `vic_ready` is high. The block returns to idle on the next cycle. `find_req` is a plain strobe, accepted only while idle.

Top module: `rrip_pa_set`

## Requirements
- R1: After reset every way's RRPV is 3, `vic_valid` is low and the bimodal fill counter is 0.
- R2: A search picks the lowest-numbered way whose `line_vld` bit is 0. Only if all ways are valid does it pick the lowest-numbered way whose RRPV is 3.
- R3: When a search cycle finds no candidate, every RRPV in the set increases by one in that cycle. `vic_valid` rises 1+k cycles after `find_req` is taken, where k is the number of such aging rounds.
- R4: With `mode_brrip` low, a demand fill writes RRPV 2.
- R5: A modulo-20 counter advances on every fill. With `mode_brrip` high, a demand fill writes RRPV 2 when that counter is 0 before the fill, and RRPV 3 otherwise.
- R6: With `pf_miss_aware` high, a prefetch fill writes RRPV 3 in either insertion mode. With it low, a prefetch fill is inserted like a demand fill.
- R7: A demand hit writes RRPV 0.
- R8: With `pf_hit_aware` high, a prefetch hit leaves the way's RRPV unchanged. With it low, a prefetch hit writes 0.
- R9: A hit or fill written in an aging cycle gives that way the written value, while all other ways still increase. If `hit_en` and `fill_en` are both high, the fill value is written.
- R10: While `vic_valid` is high and `vic_ready` is low, `vic_valid` and `vic_way` stay unchanged. After the accepting cycle, `vic_valid` is low.
- R11: A `find_req` that arrives while a search or an offer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_brrip | input | 1 | 1: bimodal insertion for demand fills; 0: static insertion |
| pf_miss_aware | input | 1 | Insert prefetch fills at RRPV 3 |
| pf_hit_aware | input | 1 | Prefetch hits leave the RRPV unchanged |
| line_vld | input | NWAYS | Per-way valid bits from the tag array |
| req_pf | input | 1 | The event this cycle is a prefetch (1) or a demand (0) |
| hit_en | input | 1 | Hit on way `ev_way` |
| fill_en | input | 1 | Fill of way `ev_way` |
| ev_way | input | WAY_W | Way of the hit or fill |
| find_req | input | 1 | Start a victim search |
| vic_valid | output | 1 | Victim way is offered |
| vic_ready | input | 1 | Controller takes the offered victim |
| vic_way | output | WAY_W | Offered victim way |

## Verification
The bench targets the case where an aging round and a written update land in the same cycle. It starts a search with every RRPV at 0, then drives a demand hit on way 0 exactly in the first search cycle. Way 0 must stay behind the other ways, so the victim is way 1 after three rounds. If aging had overwritten the hit, way 0 would have won. A simultaneous hit and fill on one way is also driven. That case is judged by the search latency, since the write value decides whether one aging round or three are needed before a way reaches 3.

// File: rtl/rrip_pa_pkg.sv
package rrip_pa_pkg;
  localparam int RRPV_W = 2;
  typedef logic [RRPV_W-1:0] rrpv_t;
  localparam rrpv_t RRPV_FAR  = 2'd3;
  localparam rrpv_t RRPV_LONG = 2'd2;
  localparam rrpv_t RRPV_NEAR = 2'd0;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_OFFER} scan_st_e;
endpackage

// File: rtl/rrip_ins_sel.sv
module rrip_ins_sel
  import rrip_pa_pkg::*;
#(
  parameter int BIP_PERIOD = 20
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fill_en,
  input  logic  req_pf,
  input  logic  mode_brrip,
  input  logic  pf_miss_aware,
  output rrpv_t ins_val
);
  localparam int CNT_W = $clog2(BIP_PERIOD);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIP_PERIOD - 1);

  logic [CNT_W-1:0] bip_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) bip_cnt <= '0;
    else if (fill_en) bip_cnt <= (bip_cnt == CNT_LAST) ? '0 : bip_cnt + 1'b1;
  end

  always_comb begin
    if (req_pf && pf_miss_aware) ins_val = RRPV_FAR;
    else if (mode_brrip)         ins_val = (bip_cnt == '0) ? RRPV_LONG : RRPV_FAR;
    else                         ins_val = RRPV_LONG;
  end

  // R5
  bip_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> bip_cnt <= CNT_LAST);
endmodule

// File: rtl/rrip_way_find.sv
module rrip_way_find
  import rrip_pa_pkg::*;
#(
  parameter int NWAYS = 16,
  localparam int WAY_W = $clog2(NWAYS)
) (
  input  logic [NWAYS-1:0]             line_vld,
  input  logic [NWAYS-1:0][RRPV_W-1:0] rrpv,
  output logic                         found,
  output logic [WAY_W-1:0]             way
);
  logic [NWAYS-1:0] inv_bit, far_bit;

  for (genvar g = 0; g < NWAYS; g++) begin : g_cand
    assign inv_bit[g] = !line_vld[g];
    assign far_bit[g] = (rrpv[g] == RRPV_FAR);
  end

  always_comb begin
    found = (|inv_bit) || (|far_bit);
    way   = '0;
    for (int i = NWAYS - 1; i >= 0; i--)
      if (far_bit[i]) way = WAY_W'(i);
    if (|inv_bit) begin
      for (int i = NWAYS - 1; i >= 0; i--)
        if (inv_bit[i]) way = WAY_W'(i);
    end
  end
endmodule

// File: rtl/rrip_age_bank.sv
module rrip_age_bank
  import rrip_pa_pkg::*;
#(
  parameter int NWAYS = 16,
  localparam int WAY_W = $clog2(NWAYS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         age_en,
  input  logic                         wr_en,
  input  logic [WAY_W-1:0]             wr_way,
  input  rrpv_t                        wr_val,
  output logic [NWAYS-1:0][RRPV_W-1:0] rrpv_q
);
  for (genvar g = 0; g < NWAYS; g++) begin : g_way
    always_ff @(posedge clk) begin
      if (!rst_n)                                  rrpv_q[g] <= RRPV_FAR;
      else if (wr_en && wr_way == WAY_W'(g))       rrpv_q[g] <= wr_val;
      else if (age_en)                             rrpv_q[g] <= rrpv_q[g] + 1'b1;
    end

    // R3
    age_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      age_en |-> rrpv_q[g] != RRPV_FAR);
  end

  // R9
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rrpv_q[$past(wr_way)] == $past(wr_val));
endmodule

// File: rtl/rrip_pa_set.sv
module rrip_pa_set
  import rrip_pa_pkg::*;
#(
  parameter int NWAYS      = 16,
  parameter int BIP_PERIOD = 20,
  localparam int WAY_W     = $clog2(NWAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_brrip,
  input  logic             pf_miss_aware,
  input  logic             pf_hit_aware,
  input  logic [NWAYS-1:0] line_vld,
  input  logic             req_pf,
  input  logic             hit_en,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] ev_way,
  input  logic             find_req,
  output logic             vic_valid,
  input  logic             vic_ready,
  output logic [WAY_W-1:0] vic_way
);
  logic [NWAYS-1:0][RRPV_W-1:0] rrpv;
  logic             found;
  logic [WAY_W-1:0] pick_way;
  rrpv_t            ins_val, wr_val;
  logic             wr_en, age_en;
  scan_st_e         st;

  rrip_ins_sel #(.BIP_PERIOD(BIP_PERIOD)) u_ins (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .req_pf(req_pf),
    .mode_brrip(mode_brrip), .pf_miss_aware(pf_miss_aware), .ins_val(ins_val)
  );

  rrip_way_find #(.NWAYS(NWAYS)) u_find (
    .line_vld(line_vld), .rrpv(rrpv), .found(found), .way(pick_way)
  );

  rrip_age_bank #(.NWAYS(NWAYS)) u_bank (
    .clk(clk), .rst_n(rst_n), .age_en(age_en), .wr_en(wr_en),
    .wr_way(ev_way), .wr_val(wr_val), .rrpv_q(rrpv)
  );

  always_comb begin
    wr_en  = 1'b0;
    wr_val = RRPV_NEAR;
    if (fill_en) begin
      wr_en  = 1'b1;
      wr_val = ins_val;
    end else if (hit_en && !(req_pf && pf_hit_aware)) begin
      wr_en  = 1'b1;
      wr_val = RRPV_NEAR;
    end
  end

  assign age_en    = (st == ST_SCAN) && !found;
  assign vic_valid = (st == ST_OFFER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      vic_way <= '0;
    end else begin
      unique case (st)
        ST_IDLE:  if (find_req) st <= ST_SCAN;
        ST_SCAN:  if (found) begin
                    vic_way <= pick_way;
                    st      <= ST_OFFER;
                  end
        ST_OFFER: if (vic_ready) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // R10
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid && !vic_ready |=> vic_valid && $stable(vic_way));

  // R2
  pick_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SCAN && found) |-> (!line_vld[pick_way] || rrpv[pick_way] == RRPV_FAR));

  // R7
  demand_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_en && !fill_en && !req_pf) |=> rrpv[$past(ev_way)] == RRPV_NEAR);

  // R6
  pf_fill_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && req_pf && pf_miss_aware) |=> rrpv[$past(ev_way)] == RRPV_FAR);

  // R8
  pf_hit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_en && !fill_en && req_pf && pf_hit_aware && !age_en)
      |=> rrpv[$past(ev_way)] == $past(rrpv[ev_way]));
endmodule

// File: tb/rrip_pa_set_bench.sv
`timescale 1ns/1ps
module rrip_pa_set_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_brrip = 1'b0, pf_miss_aware = 1'b0, pf_hit_aware = 1'b0;
  logic [15:0] line_vld = 16'hFFFF;
  logic        req_pf = 1'b0, hit_en = 1'b0, fill_en = 1'b0, find_req = 1'b0;
  logic [3:0]  ev_way = '0;
  logic        vic_valid, vic_ready = 1'b1;
  logic [3:0]  vic_way;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [1:0] m [16];
  int bipc = 0;
  int exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  rrip_pa_set u_rrip_pa_set (
    .clk(clk), .rst_n(rst_n), .mode_brrip(mode_brrip), .pf_miss_aware(pf_miss_aware),
    .pf_hit_aware(pf_hit_aware), .line_vld(line_vld), .req_pf(req_pf), .hit_en(hit_en),
    .fill_en(fill_en), .ev_way(ev_way), .find_req(find_req), .vic_valid(vic_valid),
    .vic_ready(vic_ready), .vic_way(vic_way)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every accepted victim
  always @(negedge clk) begin
    #1;
    if (rst_n && vic_valid && vic_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R11", "unexpected victim", vic_way, -1);
      else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(vic_way == e, t, "victim way", vic_way, e);
      end
    end
  end

  function automatic logic [1:0] ins_model(bit pf);
    if (pf && pf_miss_aware) return 2'd3;
    if (mode_brrip) return (bipc == 0) ? 2'd2 : 2'd3;
    return 2'd2;
  endfunction

  task automatic drive_fill(int w, bit pf);
    m[w] = ins_model(pf);
    bipc = (bipc + 1) % 20;
    fill_en = 1'b1; req_pf = pf; ev_way = 4'(w);
    @(negedge clk);
    fill_en = 1'b0; req_pf = 1'b0;
  endtask

  task automatic drive_hit(int w, bit pf);
    if (!(pf && pf_hit_aware)) m[w] = 2'd0;
    hit_en = 1'b1; req_pf = pf; ev_way = 4'(w);
    @(negedge clk);
    hit_en = 1'b0; req_pf = 1'b0;
  endtask

  task automatic model_find(output int way, output int ages);
    ages = 0;
    way = -1;
    while (way < 0) begin
      for (int i = 15; i >= 0; i--) if (m[i] == 2'd3) way = i;
      for (int i = 15; i >= 0; i--) if (!line_vld[i]) way = i;
      if (way < 0) begin
        for (int i = 0; i < 16; i++) m[i] = m[i] + 2'd1;
        ages++;
      end
    end
  endtask

  task automatic find_check(string tag);
    int w, a, n;
    model_find(w, a);
    exp_q.push_back(w); tag_q.push_back(tag);
    find_req = 1'b1;
    @(negedge clk);
    find_req = 1'b0;
    n = 0;
    while (!vic_valid && n < 20) begin @(negedge clk); n++; end
    chk(n == 1 + a, "R3", "search latency", n, 1 + a);
    @(negedge clk);
  endtask

  initial begin
    int n, w0;
    for (int i = 0; i < 16; i++) m[i] = 2'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vic_valid == 1'b0, "R1", "vic_valid after reset", vic_valid, 0);
    find_check("R1");                       // all RRPV 3 -> way 0
    line_vld = 16'hFFFB;
    find_check("R2");                       // invalid way 2 first
    line_vld = 16'hFFFF;

    for (int i = 0; i < 16; i++) drive_fill(i, 1'b0);   // R4: all at 2
    drive_hit(0, 1'b0);                                 // R7
    find_check("R4");                                   // way 1 after one round
    pf_hit_aware = 1'b1;
    drive_hit(1, 1'b1);
    find_check("R8");                                   // way 1 kept at 3
    pf_hit_aware = 1'b0;
    drive_hit(1, 1'b1);
    find_check("R8");                                   // way 1 now 0 -> way 2
    pf_miss_aware = 1'b1;
    drive_fill(1, 1'b1);
    find_check("R6");                                   // way 1 at 3
    pf_miss_aware = 1'b0;
    drive_fill(1, 1'b1);
    find_check("R6");                                   // way 1 at 2 -> way 2

    mode_brrip = 1'b1;
    for (int i = 0; i < 16; i++) drive_hit(i, 1'b0);
    for (int i = 0; i < 16; i++) drive_fill(i, 1'b0);
    for (int k = 0; k < 16; k++) begin
      find_check("R5");
      w0 = exp_q.size();
      for (int i = 0; i < 16; i++) if (m[i] == 2'd3) begin drive_hit(i, 1'b0); break; end
    end
    pf_miss_aware = 1'b1;
    for (int i = 0; i < 16; i++) drive_hit(i, 1'b0);
    drive_fill(7, 1'b1);
    find_check("R6");                                   // bimodal mode, way 7 at 3
    pf_miss_aware = 1'b0;
    mode_brrip = 1'b0;

    // R9: demand hit on way 0 in the first aging cycle
    for (int i = 0; i < 16; i++) drive_hit(i, 1'b0);
    exp_q.push_back(1); tag_q.push_back("R9");
    find_req = 1'b1;
    @(negedge clk);
    find_req = 1'b0; hit_en = 1'b1; ev_way = 4'd0;
    @(negedge clk);
    hit_en = 1'b0;
    n = 1;
    while (!vic_valid && n < 20) begin @(negedge clk); n++; end
    chk(n == 4, "R9", "latency with hit in aging cycle", n, 4);
    @(negedge clk);
    for (int i = 0; i < 16; i++) m[i] = 2'd3;
    m[0] = 2'd2;

    // R9: hit and fill together, fill value wins
    for (int i = 0; i < 16; i++) drive_hit(i, 1'b0);
    m[0] = ins_model(1'b0);
    bipc = (bipc + 1) % 20;
    hit_en = 1'b1; fill_en = 1'b1; ev_way = 4'd0;
    @(negedge clk);
    hit_en = 1'b0; fill_en = 1'b0;
    find_check("R9");

    // R10 / R11: back-pressure and ignored request
    for (int i = 0; i < 16; i++) drive_hit(i, 1'b0);
    drive_fill(9, 1'b0);
    m[9] = 2'd3;                            // seen after one round
    for (int i = 0; i < 16; i++) if (i != 9) m[i] = 2'd1;
    vic_ready = 1'b0;
    find_req = 1'b1;
    @(negedge clk);
    find_req = 1'b0;
    n = 0;
    while (!vic_valid && n < 20) begin @(negedge clk); n++; end
    chk(n == 2, "R3", "latency before back-pressure", n, 2);
    for (int k = 0; k < 3; k++) begin
      find_req = (k == 1);
      @(negedge clk);
      chk(vic_valid == 1'b1, "R10", "valid held", vic_valid, 1);
      chk(vic_way == 4'd9, "R10", "way held", vic_way, 9);
    end
    find_req = 1'b0;
    exp_q.push_back(9); tag_q.push_back("R10");
    vic_ready = 1'b1;
    @(negedge clk);
    chk(vic_valid == 1'b0, "R10", "valid after accept", vic_valid, 0);
    @(negedge clk);
    @(negedge clk);
    chk(vic_valid == 1'b0, "R11", "request during offer ignored", vic_valid, 0);
    chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "R3", "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule